// File: doc/BRIEF.md
# Three-Source Interrupt Mask and Pending Controller

This block collects three level-triggered, active-high event lines: frame received, frame sent and send failure. It keeps a per-source enable mask and a per-source pending flag, and drives one combined active-high interrupt line toward the processor. Software never writes the mask directly. It sets mask bits through one write-only register and clears them through another, so two independent drivers can each change their own bits without a read-modify-write race.

Software reads the mask through a read-only view. It reads the pending flags through a status register and clears them by writing ones. Each time software writes a one to a status bit, the block sends a one-cycle acknowledge strobe back to that event source, so the source can drop or re-arm its level.

The surrounding bus wrapper decodes addresses into per-register write strobes and a two-bit read select. The select value follows the word index of the register within the group, whose byte offsets are 0x20 for disable, 0x24 for enable, 0x28 for the mask view and 0x2C for status.

Top module: `evt_irq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the mask, pending, interrupt and acknowledge state are all zero. Reset is asserted asynchronously and released after two clock edges.
- R2: A write strobe on the enable register sets every mask bit whose write-data bit is 1. Write-data bits that are 0 leave the mask unchanged. Bit 0 is frame received, bit 1 is frame sent and bit 2 is send failure, in every register of the block.
- R3: A write strobe on the disable register clears every mask bit whose write-data bit is 1. If both strobes arrive in the same cycle, the disable wins for the bits it names.
- R4: A pending bit becomes 1 at a clock edge where its source level is high and its mask bit is 1. A high source whose mask bit is 0 leaves the pending bit unchanged.
- R5: A status write with a 1 in a bit clears that pending bit, and a 0 leaves it alone. If the source is set in the same cycle as the clear, the bit stays 1.
- R6: The interrupt output is a register that holds the OR, over all sources, of pending AND mask as it stood one cycle earlier.
- R7: Each status write with a 1 in bit i makes acknowledge bit i high for exactly the following cycle. Acknowledge bits whose write-data bit is 0 stay low.
- R8: Read select 2 returns the mask and read select 3 returns the pending bits, in data bits 2:0. Read selects 0 and 1 (the write-only registers) return zero, and data bits 31:3 always read zero.
- R9: Clearing a mask bit keeps that source's pending bit and removes it from the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| dis_wr_i | input | 1 | Write strobe for the disable register |
| en_wr_i | input | 1 | Write strobe for the enable register |
| sts_wr_i | input | 1 | Write strobe for the status register |
| wdata_i | input | 32 | Write data shared by all strobes |
| rd_sel_i | input | 2 | Register word index for reads |
| src_lvl_i | input | 3 | Raw source levels, active high |
| rdata_o | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Combined interrupt, active high |
| ack_o | output | 3 | Per-source clear acknowledge strobes |

## Verification
The mask, the pending bits and the acknowledge strobes all change at the first clock edge after the stimulus. The interrupt output lags the pending and mask state by one further edge, and read data follows the select with no delay. The bench drives every step on a falling edge and samples on the next falling edge. It therefore checks mask, pending and acknowledge against the values this step produced, and it checks the interrupt against the pending-AND-mask state of the previous step. Reads use a short settle delay after each select change within that low phase.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  // Register word index inside the group (byte offset bits 3:2).
  typedef enum logic [1:0] {
    RSEL_DISABLE = 2'd0,
    RSEL_ENABLE  = 2'd1,
    RSEL_MASK    = 2'd2,
    RSEL_STATUS  = 2'd3
  } rsel_e;

  // Source bit positions, shared by every register.
  localparam int unsigned SRC_RX_DONE = 0;
  localparam int unsigned SRC_TX_DONE = 1;
  localparam int unsigned SRC_TX_FAIL = 2;

endpackage

// File: rtl/evt_irq_rst_sync.sv
module evt_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/evt_irq_mask_reg.sv
module evt_irq_mask_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         set_wr_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] mask_o
);

  logic [N-1:0] mask_q;
  logic [N-1:0] mask_d;
  logic         mask_ce;

  assign mask_ce = set_wr_i | clr_wr_i;

  // Clear is applied after set, so a simultaneous disable wins.
  always_comb begin
    mask_d = mask_q;
    if (set_wr_i) begin
      mask_d = mask_d | bits_i;
    end
    if (clr_wr_i) begin
      mask_d = mask_d & ~bits_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mask_q <= '0;
    end else if (mask_ce) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/evt_irq_pend_bank.sv
module evt_irq_pend_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] mask_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] ack_o
);

  for (genvar gi = 0; gi < N; gi++) begin : g_src
    logic pend_q;
    logic pend_d;
    logic ack_q;
    logic ack_d;
    logic clr_hit;
    logic set_hit;

    assign clr_hit = clr_wr_i & bits_i[gi];
    assign set_hit = lvl_i[gi] & mask_i[gi];

    // Set dominates clear so a held level is never dropped.
    always_comb begin
      pend_d = set_hit | (pend_q & ~clr_hit);
      ack_d  = clr_hit;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        pend_q <= 1'b0;
        ack_q  <= 1'b0;
      end else begin
        pend_q <= pend_d;
        ack_q  <= ack_d;
      end
    end

    assign pend_o[gi] = pend_q;
    assign ack_o[gi]  = ack_q;
  end

endmodule

// File: rtl/evt_irq_read_mux.sv
module evt_irq_read_mux
  import evt_irq_pkg::*;
#(
  parameter int unsigned N  = 3,
  parameter int unsigned DW = 32
) (
  input  logic [1:0]    sel_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  pend_i,
  output logic [DW-1:0] rdata_o
);

  rsel_e sel;
  assign sel = rsel_e'(sel_i);

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      RSEL_MASK:   rdata_o[N-1:0] = mask_i;
      RSEL_STATUS: rdata_o[N-1:0] = pend_i;
      default:     rdata_o        = '0;
    endcase
  end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              dis_wr_i,
  input  logic              en_wr_i,
  input  logic              sts_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        rd_sel_i,
  input  logic [NUM_SRC-1:0] src_lvl_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [NUM_SRC-1:0] ack_o
);

  localparam int unsigned HI_W = DATA_W - NUM_SRC;

  logic               rst_sync_n;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pend_q;
  logic               irq_q;
  logic               irq_d;
  logic               unused_wdata_hi;

  assign wbits           = wdata_i[NUM_SRC-1:0];
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:DATA_W-HI_W];

  evt_irq_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_sync_n)
  );

  evt_irq_mask_reg #(
    .N (NUM_SRC)
  ) u_mask (
    .clk_i    (clk_i),
    .rst_n_i  (rst_sync_n),
    .set_wr_i (en_wr_i),
    .clr_wr_i (dis_wr_i),
    .bits_i   (wbits),
    .mask_o   (mask_q)
  );

  evt_irq_pend_bank #(
    .N (NUM_SRC)
  ) u_pend (
    .clk_i    (clk_i),
    .rst_n_i  (rst_sync_n),
    .lvl_i    (src_lvl_i),
    .mask_i   (mask_q),
    .clr_wr_i (sts_wr_i),
    .bits_i   (wbits),
    .pend_o   (pend_q),
    .ack_o    (ack_o)
  );

  evt_irq_read_mux #(
    .N  (NUM_SRC),
    .DW (DATA_W)
  ) u_rd (
    .sel_i   (rd_sel_i),
    .mask_i  (mask_q),
    .pend_i  (pend_q),
    .rdata_o (rdata_o)
  );

  always_comb begin
    irq_d = |(pend_q & mask_q);
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int unsigned N  = 3,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dis_wr,
  input logic          en_wr,
  input logic          sts_wr,
  input logic [DW-1:0] wdata,
  input logic [N-1:0]  lvl,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  pend,
  input logic [DW-1:0] rdata,
  input logic          irq,
  input logic [N-1:0]  ack
);

  // R2: enable alone sets the named mask bits
  a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !dis_wr) |=> ((mask & $past(wdata[N-1:0])) == $past(wdata[N-1:0])));

  // R3: disable clears the named bits, also against a simultaneous enable
  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> ((mask & $past(wdata[N-1:0])) == '0));

  // R2, R3: the mask moves only on a register write
  a_r3_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_wr && !dis_wr) |=> $stable(mask));

  // R4, R5: a masked high source is pending next cycle, clear or not
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(lvl & mask)) == $past(lvl & mask)));

  // R4: a pending bit rises only from a masked high source
  a_r4_no_stray_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(lvl & mask)) == '0));

  // R5: a cleared bit without a new set drops
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |=> ((pend & $past(wdata[N-1:0]) & ~$past(lvl & mask)) == '0));

  // R6: interrupt follows pending AND mask by one cycle
  a_r6_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == (|$past(pend & mask))));

  // R7: acknowledge only after a status write, on the written bits
  a_r7_ack_src: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ack == ($past(sts_wr) ? $past(wdata[N-1:0]) : '0)));

  // R8: upper read bits are zero
  a_r8_rdata_hi: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:N] == '0);

endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
  .N  (NUM_SRC),
  .DW (DATA_W)
) u_chk (
  .clk    (clk_i),
  .rst_n  (rst_sync_n),
  .dis_wr (dis_wr_i),
  .en_wr  (en_wr_i),
  .sts_wr (sts_wr_i),
  .wdata  (wdata_i),
  .lvl    (src_lvl_i),
  .mask   (mask_q),
  .pend   (pend_q),
  .rdata  (rdata_o),
  .irq    (irq_o),
  .ack    (ack_o)
);

// File: tb/tb_evt_irq_ctrl.sv
module tb_evt_irq_ctrl;

  logic        clk;
  logic        rst_n;
  logic        dis_wr;
  logic        en_wr;
  logic        sts_wr;
  logic [31:0] wdata;
  logic [1:0]  rd_sel;
  logic [2:0]  lvl;
  logic [31:0] rdata;
  logic        irq;
  logic [2:0]  ack;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  evt_irq_ctrl dut (
    .clk_i     (clk),
    .rst_n_i   (rst_n),
    .dis_wr_i  (dis_wr),
    .en_wr_i   (en_wr),
    .sts_wr_i  (sts_wr),
    .wdata_i   (wdata),
    .rd_sel_i  (rd_sel),
    .src_lvl_i (lvl),
    .rdata_o   (rdata),
    .irq_o     (irq),
    .ack_o     (ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Row fields: [18] dis [17] en [16] sts [15:13] wdata [12:10] level
  //             [9:7] mask after [6:4] pending after [3:1] ack [0] irq
  localparam int NSTEP = 15;
  localparam logic [18:0] TBL [NSTEP] = '{
    {3'b000, 3'b000, 3'b111, 3'b000, 3'b000, 3'b000, 1'b0}, // unmasked source ignored
    {3'b010, 3'b011, 3'b000, 3'b011, 3'b000, 3'b000, 1'b0}, // enable bits 0,1
    {3'b010, 3'b000, 3'b001, 3'b011, 3'b001, 3'b000, 1'b0}, // enable zeros, rx rises
    {3'b000, 3'b000, 3'b000, 3'b011, 3'b001, 3'b000, 1'b1}, // irq one cycle later
    {3'b001, 3'b000, 3'b000, 3'b011, 3'b001, 3'b000, 1'b1}, // status write of zeros
    {3'b001, 3'b001, 3'b000, 3'b011, 3'b000, 3'b001, 1'b1}, // clear rx, ack rx
    {3'b000, 3'b000, 3'b000, 3'b011, 3'b000, 3'b000, 1'b0}, // ack single cycle
    {3'b001, 3'b010, 3'b010, 3'b011, 3'b010, 3'b010, 1'b0}, // set beats clear
    {3'b100, 3'b010, 3'b000, 3'b001, 3'b010, 3'b000, 1'b1}, // disable tx done
    {3'b000, 3'b000, 3'b000, 3'b001, 3'b010, 3'b000, 1'b0}, // pending kept, irq off
    {3'b110, 3'b101, 3'b000, 3'b000, 3'b010, 3'b000, 1'b0}, // disable beats enable
    {3'b010, 3'b110, 3'b100, 3'b110, 3'b010, 3'b000, 1'b0}, // enable 1,2
    {3'b000, 3'b000, 3'b100, 3'b110, 3'b110, 3'b000, 1'b1}, // fail rises
    {3'b001, 3'b111, 3'b000, 3'b110, 3'b000, 3'b111, 1'b1}, // clear all
    {3'b000, 3'b000, 3'b000, 3'b110, 3'b000, 3'b000, 1'b0}  // quiet
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] sel, output logic [31:0] val);
    rd_sel = sel;
    #1;
    val = rdata;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    rst_n  = 1'b0;
    dis_wr = 1'b0;
    en_wr  = 1'b0;
    sts_wr = 1'b0;
    wdata  = '0;
    rd_sel = 2'd0;
    lvl    = '0;
    repeat (3) @(negedge clk);

    // R1: state while reset is held
    read_reg(2'd2, v); check("R1 mask in reset", v, 32'h0);
    check("R1 irq in reset", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: state after release
    read_reg(2'd2, v); check("R1 mask after reset", v, 32'h0);
    read_reg(2'd3, v); check("R1 pending after reset", v, 32'h0);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
    check("R1 ack after reset", {29'h0, ack}, 32'h0);

    for (int i = 0; i < NSTEP; i++) begin
      logic [18:0] row;
      row    = TBL[i];
      dis_wr = row[18];
      en_wr  = row[17];
      sts_wr = row[16];
      wdata  = {29'h0ABCDEF1, row[15:13]};
      lvl    = row[12:10];
      @(negedge clk);
      dis_wr = 1'b0;
      en_wr  = 1'b0;
      sts_wr = 1'b0;
      read_reg(2'd2, v); check($sformatf("R2/R3 mask step %0d", i), v, {29'h0, row[9:7]});
      read_reg(2'd3, v); check($sformatf("R4/R5/R9 pending step %0d", i), v, {29'h0, row[6:4]});
      check($sformatf("R7 ack step %0d", i), {29'h0, ack}, {29'h0, row[3:1]});
      check($sformatf("R6/R9 irq step %0d", i), {31'h0, irq}, {31'h0, row[0]});
    end

    // R8: write-only registers read zero; upper bits zero on live state
    lvl = 3'b110;
    @(negedge clk);
    lvl = 3'b000;
    read_reg(2'd0, v); check("R8 disable reads zero", v, 32'h0);
    read_reg(2'd1, v); check("R8 enable reads zero", v, 32'h0);
    read_reg(2'd3, v); check("R8 status view", v, 32'h6);
    read_reg(2'd2, v); check("R8 mask view", v, 32'h6);

    // R1: asynchronous reset mid-run clears everything at once
    #1;
    rst_n = 1'b0;
    #1;
    read_reg(2'd2, v); check("R1 mask on async reset", v, 32'h0);
    read_reg(2'd3, v); check("R1 pending on async reset", v, 32'h0);
    check("R1 irq on async reset", {31'h0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_reg(2'd2, v); check("R1 mask after second release", v, 32'h0);

    done = 1'b1;
    finish_run();
  end

endmodule